// File: doc/BRIEF.md
# Endpoint interrupt clear sequencer

This block keeps one interrupt status bit per physical endpoint of a USB device controller with 32 physical endpoints. Bit positions follow the endpoint numbering: bit 2n belongs to receive (OUT) endpoint n and bit 2n+1 to transmit (IN) endpoint n, for n from 0 to 15. A routing mask decides, per endpoint, where an incoming event lands. When the mask bit is 1 the event raises the interrupt status bit. When it is 0 the event raises the endpoint's bit in a DMA-request status vector.

Software clears status bits by writing ones to a write-only clear mask. Each requested endpoint is not just reset. It is served by a select-endpoint/clear-interrupt command sent to an endpoint-status engine over a request/acknowledge port, and the engine returns an 8-bit status byte. A command-data-full flag drops as soon as a clear is requested. The flag rises again when the whole batch has finished, and by then the command-data output holds the status byte of the lowest endpoint in the batch.

The sequencer is a three-state machine:
- `SEQ_IDLE`: nothing is pending. It moves to `SEQ_ISSUE` when the pending mask becomes non-zero.
- `SEQ_ISSUE`: a one-cycle request for the highest pending endpoint. It always moves to `SEQ_WAIT`.
- `SEQ_WAIT`: holds until the acknowledge. If more bits are still pending it moves to `SEQ_ISSUE`; otherwise it returns to `SEQ_IDLE`.

Top module: `ep_irq_clear_seq`

## Requirements
- R1: After reset the status vector, the DMA-request vector, the routing mask, `irq`, `cmd_full`, `cmd_data` and `eng_req` are all zero.
- R2: An event on an endpoint whose routing bit is 1 sets that endpoint's status bit on the next clock edge. Bit 2n is OUT endpoint n and bit 2n+1 is IN endpoint n.
- R3: An event on an endpoint whose routing bit is 0 sets that endpoint's bit in `dma_req_status`, and does not touch its status bit. A DMA-request bit stays set until reset.
- R4: A write with `wr_sel`=0 loads `wr_data` into the routing mask.
- R5: A write with `wr_sel`=1 starts one clear command for every one bit of `wr_data`. Zero bits have no effect, and an all-zero write issues no request.
- R6: `cmd_full` is 0 in the cycle after any clear write with at least one bit set.
- R7: When a clear command is acknowledged, the endpoint's status bit is 0 on the next edge and `cmd_data` holds `eng_status`.
- R8: Pending clears are served one at a time, from the highest bit index down. `cmd_full` returns to 1 only after the last acknowledge, and `cmd_data` then holds the lowest endpoint's status byte.
- R9: A clear write that arrives during a sequence is merged into the pending set. It does not restart the command in flight, and each endpoint is served only once.
- R10: `eng_req` is a single-cycle pulse with the endpoint index on `eng_idx`. The block waits any number of cycles (at least one) for `eng_ack`.
- R11: An enabled event that arrives in the same cycle as that endpoint's acknowledge leaves its status bit set.
- R12: `irq` is 1 exactly when some status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 routing mask, 1 clear mask |
| wr_data | input | 32 | Write data, one bit per endpoint |
| ep_evt | input | 32 | Per-endpoint event pulses |
| eng_ack | input | 1 | Engine acknowledge |
| eng_status | input | 8 | Status byte returned with the acknowledge |
| eng_req | output | 1 | Single-cycle command request |
| eng_idx | output | 5 | Endpoint index for the request |
| ep_int_status | output | 32 | Interrupt status vector |
| dma_req_status | output | 32 | DMA-request status vector |
| irq | output | 1 | OR of all status bits |
| cmd_full | output | 1 | Command-data-full flag |
| cmd_data | output | 8 | Status byte of the last completed clear |

## Verification
Every endpoint is cleared alone, which shows that each index reaches the engine and clears only its own bit. The engine latency varies with the index. A sparse multi-bit mask shows the descending service order and which status byte is left last. A clear written into a running batch, overlapping one bit that is already pending, separates merging from restarting and from double service. An all-zero write, an event on the acknowledge cycle, and routing masks of alternating and solid ones tell the no-effect, collision, and slave versus DMA paths apart.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/ep_msb_pick.sv
module ep_msb_pick #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);

    // Last match in ascending order wins: highest set bit
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
    end

    assign any = |vec;

endmodule

// File: rtl/ep_status_bank.sv
module ep_status_bank #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  evt,
    input  logic [N-1:0]  route_en,
    input  logic          clr_fire,
    input  logic [IW-1:0] clr_idx,
    output logic [N-1:0]  status,
    output logic [N-1:0]  dma_st
);

    logic [N-1:0] status_q;
    logic [N-1:0] dma_q;

    for (genvar g = 0; g < N; g++) begin : g_ep
        localparam logic [IW-1:0] MY_IDX = IW'(g);
        logic hit;

        assign hit = clr_fire && (clr_idx == MY_IDX);

        // A fresh enabled event outranks a completing clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                status_q[g] <= 1'b0;
                dma_q[g]    <= 1'b0;
            end else begin
                status_q[g] <= (status_q[g] & ~hit) | (evt[g] & route_en[g]);
                dma_q[g]    <= dma_q[g] | (evt[g] & ~route_en[g]);
            end
        end
    end

    assign status = status_q;
    assign dma_st = dma_q;

endmodule

// File: rtl/ep_clear_fsm.sv
module ep_clear_fsm
    import ep_irq_pkg::*;
#(
    parameter int N  = 32,
    parameter int IW = $clog2(N),
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_wr,
    input  logic [N-1:0]  clr_mask,
    output logic          eng_req,
    output logic [IW-1:0] eng_idx,
    input  logic          eng_ack,
    input  logic [SW-1:0] eng_status,
    output logic          done_fire,
    output logic [IW-1:0] done_idx,
    output logic          cmd_full,
    output logic [SW-1:0] cmd_data
);

    seq_state_e    state_q, state_d;
    logic [N-1:0]  pend_q, pend_d, done_mask, wr_bits;
    logic [IW-1:0] cur_q;
    logic [IW-1:0] nxt_idx;
    logic          nxt_any;
    logic          full_q;
    logic [SW-1:0] data_q;

    ep_msb_pick #(.N(N), .IW(IW)) u_pick (
        .vec (pend_d),
        .idx (nxt_idx),
        .any (nxt_any)
    );

    assign done_fire = (state_q == SEQ_WAIT) && eng_ack;
    assign done_mask = done_fire ? (N'(1) << cur_q) : '0;
    assign wr_bits   = clr_wr ? clr_mask : '0;
    assign pend_d    = (pend_q & ~done_mask) | wr_bits;

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:  if (nxt_any) state_d = SEQ_ISSUE;
            SEQ_ISSUE: state_d = SEQ_WAIT;
            SEQ_WAIT:  if (eng_ack) state_d = nxt_any ? SEQ_ISSUE : SEQ_IDLE;
            default:   state_d = SEQ_IDLE;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            pend_q  <= '0;
            cur_q   <= '0;
            full_q  <= 1'b0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            if (state_d == SEQ_ISSUE && state_q != SEQ_ISSUE) begin
                cur_q <= nxt_idx;
            end
            if (|wr_bits) begin
                full_q <= 1'b0;
            end else if (done_fire && !nxt_any) begin
                full_q <= 1'b1;
            end
            if (done_fire) begin
                data_q <= eng_status;
            end
        end
    end

    // Output process
    always_comb begin
        eng_req  = (state_q == SEQ_ISSUE);
        eng_idx  = cur_q;
        done_idx = cur_q;
        cmd_full = full_q;
        cmd_data = data_q;
    end

endmodule

// File: rtl/ep_irq_clear_seq.sv
module ep_irq_clear_seq #(
    parameter int NUM_EP = 32,
    parameter int STAT_W = 8,
    localparam int IW    = $clog2(NUM_EP)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [NUM_EP-1:0] wr_data,
    input  logic [NUM_EP-1:0] ep_evt,
    input  logic              eng_ack,
    input  logic [STAT_W-1:0] eng_status,
    output logic              eng_req,
    output logic [IW-1:0]     eng_idx,
    output logic [NUM_EP-1:0] ep_int_status,
    output logic [NUM_EP-1:0] dma_req_status,
    output logic              irq,
    output logic              cmd_full,
    output logic [STAT_W-1:0] cmd_data
);

    logic [NUM_EP-1:0] route_q;
    logic              clr_wr;
    logic              done_fire;
    logic [IW-1:0]     done_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
        end else if (wr_en && !wr_sel) begin
            route_q <= wr_data;
        end
    end

    assign clr_wr = wr_en && wr_sel;

    ep_clear_fsm #(.N(NUM_EP), .IW(IW), .SW(STAT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_wr     (clr_wr),
        .clr_mask   (wr_data),
        .eng_req    (eng_req),
        .eng_idx    (eng_idx),
        .eng_ack    (eng_ack),
        .eng_status (eng_status),
        .done_fire  (done_fire),
        .done_idx   (done_idx),
        .cmd_full   (cmd_full),
        .cmd_data   (cmd_data)
    );

    ep_status_bank #(.N(NUM_EP), .IW(IW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (ep_evt),
        .route_en (route_q),
        .clr_fire (done_fire),
        .clr_idx  (done_idx),
        .status   (ep_int_status),
        .dma_st   (dma_req_status)
    );

    assign irq = |ep_int_status;

endmodule

// File: rtl/ep_irq_clear_chk.sv
module ep_irq_clear_chk #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic         wr_sel,
    input logic [N-1:0] wr_data,
    input logic [N-1:0] ep_evt,
    input logic [N-1:0] route,
    input logic [N-1:0] status,
    input logic [N-1:0] dma_st,
    input logic         cmd_full,
    input logic         eng_req,
    input logic         eng_ack
);

    // R10
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> !eng_req);

    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && (wr_data != '0)) |=> !cmd_full);

    // R8
    full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_full) |-> $past(eng_ack));

    // R3
    dma_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((dma_st & $past(dma_st)) == $past(dma_st)));

    // R2
    slave_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(ep_evt & route) & ~status) == '0));

    // R3
    dma_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(ep_evt & ~route) & ~dma_st) == '0));

endmodule

bind ep_irq_clear_seq ep_irq_clear_chk #(.N(NUM_EP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .ep_evt   (ep_evt),
    .route    (route_q),
    .status   (ep_int_status),
    .dma_st   (dma_req_status),
    .cmd_full (cmd_full),
    .eng_req  (eng_req),
    .eng_ack  (eng_ack)
);

// File: tb/ep_irq_clear_seq_tb_top.sv
module ep_irq_clear_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] evt_tb = '0;
    logic [31:0] evt_eng = '0;
    logic [31:0] ep_evt;
    logic        eng_ack = 1'b0;
    logic [7:0]  eng_status = '0;
    logic        eng_req;
    logic [4:0]  eng_idx;
    logic [31:0] ep_int_status;
    logic [31:0] dma_req_status;
    logic        irq;
    logic        cmd_full;
    logic [7:0]  cmd_data;

    int n_chk = 0;
    int n_err = 0;
    int log_idx [0:511];
    int log_n = 0;
    bit collide = 1'b0;

    assign ep_evt = evt_tb | evt_eng;

    always #10 clk = ~clk;

    ep_irq_clear_seq dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .wr_sel         (wr_sel),
        .wr_data        (wr_data),
        .ep_evt         (ep_evt),
        .eng_ack        (eng_ack),
        .eng_status     (eng_status),
        .eng_req        (eng_req),
        .eng_idx        (eng_idx),
        .ep_int_status  (ep_int_status),
        .dma_req_status (dma_req_status),
        .irq            (irq),
        .cmd_full       (cmd_full),
        .cmd_data       (cmd_data)
    );

    function automatic logic [7:0] stat_of(int i);
        return 8'((i * 37 + 11) ^ 8'h5A);
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // Engine model: latency 1..4 cycles depending on index
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (eng_req) begin
                automatic int id = int'(eng_idx);
                log_idx[log_n] = id;
                log_n++;
                repeat (1 + (id % 4)) @(posedge clk);
                #1;
                eng_ack = 1'b1;
                eng_status = stat_of(id);
                if (collide) evt_eng = 32'd1 << id;
                @(posedge clk);
                #1;
                eng_ack = 1'b0;
                evt_eng = '0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    task automatic reg_write(logic sel, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_evt(logic [31:0] v);
        @(negedge clk);
        evt_tb = v;
        @(negedge clk);
        evt_tb = '0;
    endtask

    task automatic wait_full();
        for (int k = 0; k < 400; k++) begin
            if (cmd_full) break;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] exp_st;
        int          base;
        int          cnt;
        logic [31:0] mask;

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 status", ep_int_status, 0);
        chk("R1 dma", dma_req_status, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        chk("R1 cmd_full", {31'd0, cmd_full}, 0);
        chk("R1 cmd_data", {24'd0, cmd_data}, 0);
        chk("R1 eng_req", {31'd0, eng_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        pulse_evt(32'h0000_0001);
        chk("R1 R3 route mask zero after reset", dma_req_status, 32'h1);
        chk("R1 status untouched", ep_int_status, 0);

        // R4 R2 R3: receive endpoints routed to slave, transmit to DMA
        reg_write(1'b0, 32'h5555_5555);
        pulse_evt(32'hFFFF_FFFF);
        chk("R2 even bits set", ep_int_status, 32'h5555_5555);
        chk("R3 odd bits to dma", dma_req_status, 32'hAAAA_AAAB);
        chk("R12 irq high", {31'd0, irq}, 1);

        reg_write(1'b0, 32'hFFFF_FFFF);
        pulse_evt(32'hFFFF_FFFF);
        chk("R4 all routed to slave", ep_int_status, 32'hFFFF_FFFF);
        chk("R3 dma sticky", dma_req_status, 32'hAAAA_AAAB);

        // R5 R6 R7 R10 R12: single-endpoint sweep
        exp_st = 32'hFFFF_FFFF;
        for (int i = 0; i < 32; i++) begin
            base = log_n;
            reg_write(1'b1, 32'd1 << i);
            chk($sformatf("R6 full low ep%0d", i), {31'd0, cmd_full}, 0);
            wait_full();
            exp_st &= ~(32'd1 << i);
            chk($sformatf("R7 data ep%0d", i), {24'd0, cmd_data}, {24'd0, stat_of(i)});
            chk($sformatf("R7 status ep%0d", i), ep_int_status, exp_st);
            chk($sformatf("R10 one req ep%0d", i), log_n - base, 1);
            chk($sformatf("R10 idx ep%0d", i), log_idx[base], i);
            chk($sformatf("R12 irq ep%0d", i), {31'd0, irq}, {31'd0, exp_st != 0});
        end

        // R5 zero write has no effect
        pulse_evt(32'hFFFF_FFFF);
        base = log_n;
        reg_write(1'b1, 32'h0);
        repeat (10) @(negedge clk);
        chk("R5 zero write no req", log_n - base, 0);
        chk("R5 zero write flag", {31'd0, cmd_full}, 1);
        chk("R5 zero write status", ep_int_status, 32'hFFFF_FFFF);

        // R8 multi-bit batch, descending order, lowest status last
        mask = 32'h9000_0124;
        base = log_n;
        reg_write(1'b1, mask);
        wait_full();
        chk("R8 count", log_n - base, $countones(mask));
        cnt = 0;
        for (int i = 31; i >= 0; i--) begin
            if (mask[i]) begin
                chk("R8 order", log_idx[base + cnt], i);
                cnt++;
            end
        end
        chk("R8 last data", {24'd0, cmd_data}, {24'd0, stat_of(2)});
        chk("R8 status", ep_int_status, ~mask);

        // R9 write merged mid-sequence
        pulse_evt(32'hFFFF_FFFF);
        base = log_n;
        reg_write(1'b1, 32'h0000_F000);
        for (int k = 0; k < 50; k++) begin
            if (log_n > base) break;
            @(negedge clk);
        end
        reg_write(1'b1, 32'h0000_2003);
        chk("R9 full low after merge", {31'd0, cmd_full}, 0);
        wait_full();
        chk("R9 count", log_n - base, 6);
        chk("R9 order0", log_idx[base + 0], 15);
        chk("R9 order1", log_idx[base + 1], 14);
        chk("R9 order2", log_idx[base + 2], 13);
        chk("R9 order3", log_idx[base + 3], 12);
        chk("R9 order4", log_idx[base + 4], 1);
        chk("R9 order5", log_idx[base + 5], 0);
        chk("R9 data", {24'd0, cmd_data}, {24'd0, stat_of(0)});
        chk("R9 status", ep_int_status, ~32'h0000_F003);

        // R11 event collides with completion
        pulse_evt(32'hFFFF_FFFF);
        collide = 1'b1;
        reg_write(1'b1, 32'h0000_0020);
        wait_full();
        collide = 1'b0;
        chk("R11 bit kept", ep_int_status, 32'hFFFF_FFFF);
        chk("R11 data", {24'd0, cmd_data}, {24'd0, stat_of(5)});
        reg_write(1'b1, 32'h0000_0020);
        wait_full();
        chk("R7 bit cleared without collision", ep_int_status, ~32'h20);

        // R12 clear everything
        base = log_n;
        reg_write(1'b1, 32'hFFFF_FFFF);
        wait_full();
        chk("R12 status empty", ep_int_status, 0);
        chk("R12 irq low", {31'd0, irq}, 0);
        chk("R8 full batch count", log_n - base, 32);
        chk("R8 full batch data", {24'd0, cmd_data}, {24'd0, stat_of(0)});

        // R2 R3 disabled routing keeps status clear
        reg_write(1'b0, 32'h0);
        pulse_evt(32'h0000_0080);
        chk("R3 disabled status", ep_int_status, 0);
        chk("R3 disabled dma", dma_req_status, 32'hAAAA_AAAB);
        chk("R12 irq stays low", {31'd0, irq}, 0);

        summary();
    end

endmodule